// File: doc/BRIEF.md
# Streaming equi-depth histogram builder

This block sits beside a stream of histogram bins that arrive one per cycle in ascending bin order, each carrying the frequency of one value. It groups consecutive bins into buckets whose total frequencies are roughly equal. For every bucket it emits two 32-bit words: the bucket's summed frequency and the number of bins it spans.

A request begins with a start pulse that carries the desired bucket count and the total number of items in the table. A sequential divider derives the per-bucket frequency target from these two values. While the division runs, the block holds its ready output low. Once ready is high, the block takes one bin per cycle without stalls. In threshold mode, a bucket closes as soon as its running sum reaches the target. In flag mode, a boundary flag attached to each bin decides where a bucket closes. A bin is never split, so a bucket may overshoot the target.

An end-of-scan pulse flushes any partly filled bucket, raises a one-cycle done pulse and returns the block to idle. Every accepted bin is also copied unchanged to a chain output two cycles later, so that further statistic blocks can follow this one.

Top module: `eqd_hist_builder`

## Requirements
- R1: After a start pulse in idle, ready_o rises within 40 cycles. The frequency target is then floor(total / buckets). A bucket count of 0 is treated as 1.
- R2: ready_o is high only between the end of the division and the end-of-scan pulse. A bin offered while ready_o is low is neither counted nor forwarded, and a start pulse outside idle has no effect.
- R3: In threshold mode (cfg_flag_mode_i = 0), an accepted bin whose addition brings the running sum to at least the target closes the bucket. That bin belongs to the closing bucket. One cycle after the bin's edge, bkt_valid_o is high for one cycle with bkt_sum_o holding the sum and bkt_bins_o holding the bin count, and both accumulators restart from zero. A target of 0 therefore closes a bucket on every bin.
- R4: A bin's count is never divided between buckets. The emitted sum includes the whole closing bin, even when it exceeds the target.
- R5: In flag mode (cfg_flag_mode_i = 1), a bucket closes exactly on an accepted bin with bin_flag_i = 1, and that bin belongs to the bucket. The target is ignored.
- R6: On scan_end_i while ready_o is high, the bin offered in the same cycle is processed first. Any remaining non-empty bucket is then emitted in the same output cycle, and done_o pulses for one cycle. No bucket with zero bins is ever emitted.
- R7: Every accepted bin appears on fwd_count_o and fwd_flag_o with fwd_valid_o high exactly 2 cycles after its accepting edge. fwd_valid_o is low otherwise.
- R8: During a scan, ready_o stays high on every cycle, with or without valid bins, until scan_end_i is accepted.
- R9: The bucket count, total and mode are captured at each start, so consecutive requests may use different settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_start_i | input | 1 | Start a request (taken in idle only) |
| cfg_buckets_i | input | 16 | Requested bucket count |
| cfg_total_i | input | 32 | Total item count of the table |
| cfg_flag_mode_i | input | 1 | 1 = close buckets on bin flags |
| ready_o | output | 1 | Bins are accepted |
| bin_valid_i | input | 1 | Bin present |
| bin_count_i | input | 32 | Bin frequency |
| bin_flag_i | input | 1 | Boundary flag for flag mode |
| scan_end_i | input | 1 | End of the bin stream |
| fwd_valid_o | output | 1 | Forwarded bin present |
| fwd_count_o | output | 32 | Forwarded bin frequency |
| fwd_flag_o | output | 1 | Forwarded boundary flag |
| bkt_valid_o | output | 1 | Bucket result present |
| bkt_sum_o | output | 32 | Bucket frequency sum |
| bkt_bins_o | output | 32 | Bins in the bucket |
| done_o | output | 1 | Scan finished pulse |

## Verification
The hardest case to reach is the end of a scan. Here the last bin, the threshold test and the flush all act in the same cycle. The bench ends one scan with scan_end_i on the closing bin, so that no flush may follow. It ends another right after an exact close, so that no empty bucket may appear. It also ends several scans after a partial bucket, so that a flush is required. Junk bins are driven during every division window and after done, which shows that the ready gating has no side effects on either the forward port or the bucket port.

// File: rtl/eqd_pkg.sv
package eqd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_SCAN = 2'd2
  } eqd_state_e;
endpackage

// File: rtl/eqd_limit_div.sv
module eqd_limit_div #(
  parameter int W  = 32,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  dividend_i,
  input  logic [DW-1:0] divisor_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [W-1:0]  quot_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  num_q, den_q, quo_q;
  logic [W:0]    rem_q, rem_sh;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  assign rem_sh = {rem_q[W-1:0], quo_q[W-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        num_q  <= dividend_i;
        den_q  <= W'(divisor_i);
        quo_q  <= dividend_i;
        rem_q  <= '0;
        cnt_q  <= CW'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        // restoring step: one quotient bit per cycle
        if (rem_sh >= {1'b0, den_q}) begin
          rem_q <= rem_sh - {1'b0, den_q};
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= rem_sh;
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = quo_q;

  AST_DIV_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (({W'(0), quo_q} * {W'(0), den_q}) <= {W'(0), num_q}) &&
               (({W'(0), num_q} - ({W'(0), quo_q} * {W'(0), den_q})) < {W'(0), den_q})); // R1
endmodule

// File: rtl/eqd_fwd_pipe.sv
module eqd_fwd_pipe #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] count_i,
  input  logic         flag_i,
  output logic         valid_o,
  output logic [W-1:0] count_o,
  output logic         flag_o
);
  logic         v_q [STAGES];
  logic [W-1:0] c_q [STAGES];
  logic         f_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic         v_in;
    logic [W-1:0] c_in;
    logic         f_in;
    if (s == 0) begin : g_head
      assign v_in = valid_i;
      assign c_in = count_i;
      assign f_in = flag_i;
    end else begin : g_body
      assign v_in = v_q[s-1];
      assign c_in = c_q[s-1];
      assign f_in = f_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[s] <= 1'b0;
        c_q[s] <= '0;
        f_q[s] <= 1'b0;
      end else begin
        v_q[s] <= v_in;
        c_q[s] <= c_in;
        f_q[s] <= f_in;
      end
    end
  end

  assign valid_o = v_q[STAGES-1];
  assign count_o = c_q[STAGES-1];
  assign flag_o  = f_q[STAGES-1];

  AST_FWD_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, STAGES)); // R7
  AST_FWD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (count_o == $past(count_i, STAGES)) && (flag_o == $past(flag_i, STAGES))); // R7
endmodule

// File: rtl/eqd_bucket_acc.sv
module eqd_bucket_acc #(
  parameter int CW = 32,
  parameter int SW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          mode_i,
  input  logic [SW-1:0] limit_i,
  input  logic          take_i,
  input  logic [CW-1:0] count_i,
  input  logic          flag_i,
  input  logic          end_i,
  output logic          bkt_valid_o,
  output logic [SW-1:0] bkt_sum_o,
  output logic [SW-1:0] bkt_bins_o,
  output logic          done_o
);
  logic [SW-1:0] sum_q, bins_q, sum_add, bins_add;
  logic          mode_q, hit;
  logic          vld_q, flush_q, done_q;
  logic [SW-1:0] osum_q, obins_q;

  assign sum_add  = sum_q + SW'(count_i);
  assign bins_add = bins_q + 1'b1;
  assign hit      = mode_q ? flag_i : (sum_add >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q   <= '0;
      bins_q  <= '0;
      mode_q  <= 1'b0;
      vld_q   <= 1'b0;
      flush_q <= 1'b0;
      done_q  <= 1'b0;
      osum_q  <= '0;
      obins_q <= '0;
    end else begin
      vld_q   <= 1'b0;
      flush_q <= 1'b0;
      done_q  <= 1'b0;
      if (clear_i) begin
        sum_q  <= '0;
        bins_q <= '0;
        mode_q <= mode_i;
      end else begin
        if (take_i) begin
          if (hit) begin
            vld_q   <= 1'b1;
            osum_q  <= sum_add;
            obins_q <= bins_add;
            sum_q   <= '0;
            bins_q  <= '0;
          end else begin
            sum_q  <= sum_add;
            bins_q <= bins_add;
          end
        end
        if (end_i) begin
          done_q <= 1'b1;
          sum_q  <= '0;
          bins_q <= '0;
          if (take_i && !hit) begin
            vld_q   <= 1'b1;
            flush_q <= 1'b1;
            osum_q  <= sum_add;
            obins_q <= bins_add;
          end else if (!take_i && bins_q != '0) begin
            vld_q   <= 1'b1;
            flush_q <= 1'b1;
            osum_q  <= sum_q;
            obins_q <= bins_q;
          end
        end
      end
    end
  end

  assign bkt_valid_o = vld_q;
  assign bkt_sum_o   = osum_q;
  assign bkt_bins_o  = obins_q;
  assign done_o      = done_q;

  AST_NO_EMPTY_BUCKET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (obins_q != '0)); // R6
  AST_THRESH_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !flush_q && !mode_q) |-> (osum_q >= limit_i)); // R3
  AST_FLAG_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !flush_q && mode_q) |-> $past(take_i && flag_i)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R6
  AST_FLUSH_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_q |-> done_q); // R6
endmodule

// File: rtl/eqd_hist_builder.sv
module eqd_hist_builder #(
  parameter int CNT_W      = 32,
  parameter int BKT_W      = 16,
  parameter int FWD_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_start_i,
  input  logic [BKT_W-1:0] cfg_buckets_i,
  input  logic [CNT_W-1:0] cfg_total_i,
  input  logic             cfg_flag_mode_i,
  output logic             ready_o,
  input  logic             bin_valid_i,
  input  logic [CNT_W-1:0] bin_count_i,
  input  logic             bin_flag_i,
  input  logic             scan_end_i,
  output logic             fwd_valid_o,
  output logic [CNT_W-1:0] fwd_count_o,
  output logic             fwd_flag_o,
  output logic             bkt_valid_o,
  output logic [CNT_W-1:0] bkt_sum_o,
  output logic [CNT_W-1:0] bkt_bins_o,
  output logic             done_o
);
  import eqd_pkg::*;

  eqd_state_e       state_q;
  logic             start_ok, take, end_ok;
  logic             div_busy, div_done;
  logic [CNT_W-1:0] div_quot, limit_q;
  logic [BKT_W-1:0] buckets_eff;

  assign start_ok    = cfg_start_i && (state_q == ST_IDLE);
  assign ready_o     = (state_q == ST_SCAN);
  assign take        = bin_valid_i && ready_o;
  assign end_ok      = scan_end_i && ready_o;
  assign buckets_eff = (cfg_buckets_i == '0) ? BKT_W'(1) : cfg_buckets_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      limit_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_ok) state_q <= ST_DIV;
        ST_DIV: if (div_done) begin
          limit_q <= div_quot;
          state_q <= ST_SCAN;
        end
        ST_SCAN: if (end_ok) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  eqd_limit_div #(.W(CNT_W), .DW(BKT_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_ok),
    .dividend_i(cfg_total_i),
    .divisor_i (buckets_eff),
    .busy_o    (div_busy),
    .done_o    (div_done),
    .quot_o    (div_quot)
  );

  eqd_fwd_pipe #(.W(CNT_W), .STAGES(FWD_STAGES)) u_fwd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(take),
    .count_i(bin_count_i),
    .flag_i (bin_flag_i),
    .valid_o(fwd_valid_o),
    .count_o(fwd_count_o),
    .flag_o (fwd_flag_o)
  );

  eqd_bucket_acc #(.CW(CNT_W), .SW(CNT_W)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (start_ok),
    .mode_i     (cfg_flag_mode_i),
    .limit_i    (limit_q),
    .take_i     (take),
    .count_i    (bin_count_i),
    .flag_i     (bin_flag_i),
    .end_i      (end_ok),
    .bkt_valid_o(bkt_valid_o),
    .bkt_sum_o  (bkt_sum_o),
    .bkt_bins_o (bkt_bins_o),
    .done_o     (done_o)
  );

  AST_READY_NOT_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !div_busy); // R2
  AST_LIMIT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $past(ready_o)) |-> $stable(limit_q)); // R1
  AST_READY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !scan_end_i) |=> ready_o); // R8
endmodule

// File: tb/tb_eqd_hist_builder.sv
module tb_eqd_hist_builder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_start = 1'b0;
  logic [15:0] cfg_buckets = '0;
  logic [31:0] cfg_total = '0;
  logic        cfg_mode = 1'b0;
  logic        ready;
  logic        bin_valid = 1'b0;
  logic [31:0] bin_count = '0;
  logic        bin_flag = 1'b0;
  logic        scan_end = 1'b0;
  logic        fwd_valid, fwd_flag, bkt_valid, done;
  logic [31:0] fwd_count, bkt_sum, bkt_bins;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  eqd_hist_builder dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_start_i(cfg_start), .cfg_buckets_i(cfg_buckets),
    .cfg_total_i(cfg_total), .cfg_flag_mode_i(cfg_mode),
    .ready_o(ready),
    .bin_valid_i(bin_valid), .bin_count_i(bin_count), .bin_flag_i(bin_flag),
    .scan_end_i(scan_end),
    .fwd_valid_o(fwd_valid), .fwd_count_o(fwd_count), .fwd_flag_o(fwd_flag),
    .bkt_valid_o(bkt_valid), .bkt_sum_o(bkt_sum), .bkt_bins_o(bkt_bins),
    .done_o(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R7 forward monitor: accepted bin seen at a negedge reappears two negedges later
  logic        e1_v = 0, e2_v = 0, e1_f = 0, e2_f = 0;
  logic [31:0] e1_c = 0, e2_c = 0;
  logic        mon_on = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (e2_v || fwd_valid) begin
        check(fwd_valid == e2_v, "R7", "fwd_valid", fwd_valid, e2_v);
        if (e2_v) begin
          check(fwd_count == e2_c, "R7", "fwd_count", fwd_count, e2_c);
          check(fwd_flag == e2_f, "R7", "fwd_flag", fwd_flag, e2_f);
        end
      end
    end
    e2_v = e1_v; e2_c = e1_c; e2_f = e1_f;
    e1_v = bin_valid && ready; e1_c = bin_count; e1_f = bin_flag;
  end

  // bucket and done capture
  logic [31:0] m_sum [32];
  logic [31:0] m_bins [32];
  int m_n = 0;
  int done_n = 0;
  always @(negedge clk) begin
    if (bkt_valid && m_n < 32) begin
      m_sum[m_n] = bkt_sum;
      m_bins[m_n] = bkt_bins;
      m_n++;
    end
    if (done) done_n++;
  end

  // stimulus tables
  int s_cnt [32];
  bit s_flag [32];
  bit s_gap [32];
  int e_sum [32];
  int e_bins [32];

  task automatic set_bin(input int i, input int c, input bit f, input bit g);
    s_cnt[i] = c; s_flag[i] = f; s_gap[i] = g;
  endtask

  task automatic run_scan(input string req, input bit mode, input int total,
                          input int buckets, input int n, input bit end_on_last);
    int lim, acc, bn, en, waitc;
    bit hit;
    lim = total / ((buckets == 0) ? 1 : buckets);
    acc = 0; bn = 0; en = 0;
    for (int i = 0; i < n; i++) begin
      acc += s_cnt[i]; bn++;
      hit = mode ? s_flag[i] : (acc >= lim);
      if (hit || (end_on_last && i == n - 1)) begin
        e_sum[en] = acc; e_bins[en] = bn; en++; acc = 0; bn = 0;
      end
    end
    if (bn != 0) begin
      e_sum[en] = acc; e_bins[en] = bn; en++;
    end
    m_n = 0; done_n = 0;
    @(posedge clk); #1;
    cfg_start = 1; cfg_buckets = 16'(buckets); cfg_total = 32'(total); cfg_mode = mode;
    @(posedge clk); #1;
    cfg_start = 0;
    // junk bins while ready is low must be ignored (R2)
    waitc = 0;
    while (!ready && waitc < 100) begin
      bin_valid = 1; bin_count = 32'd777; bin_flag = 1;
      // restart attempt outside idle must be ignored (R2)
      cfg_start = (waitc == 3); cfg_buckets = 16'd1; cfg_total = 32'd5; cfg_mode = !mode;
      @(posedge clk); #1;
      waitc++;
    end
    cfg_start = 0;
    check(ready == 1 && waitc <= 40, "R1", "cycles to ready", waitc, 40);
    for (int i = 0; i < n; i++) begin
      bin_valid = 1; bin_count = 32'(s_cnt[i]); bin_flag = s_flag[i];
      scan_end = end_on_last && (i == n - 1);
      @(posedge clk); #1;
      if (!scan_end) check(ready == 1, "R8", "ready during scan", ready, 1);
      if (s_gap[i]) begin
        bin_valid = 0; scan_end = 0;
        @(posedge clk); #1;
        check(ready == 1, "R8", "ready in gap", ready, 1);
      end
    end
    bin_valid = 0; bin_flag = 0;
    if (!end_on_last) begin
      scan_end = 1;
      @(posedge clk); #1;
    end
    scan_end = 0;
    repeat (3) @(posedge clk);
    #1;
    check(ready == 0, "R2", "ready after end", ready, 0);
    check(done_n == 1, "R6", "done pulses", done_n, 1);
    check(m_n == en, req, "bucket count", m_n, en);
    for (int k = 0; k < en && k < m_n; k++) begin
      check(m_sum[k] == 32'(e_sum[k]), req, "bucket sum", m_sum[k], e_sum[k]);
      check(m_bins[k] == 32'(e_bins[k]), req, "bucket bins", m_bins[k], e_bins[k]);
    end
    // bins offered in idle change nothing (R2)
    m_n = 0;
    bin_valid = 1; bin_count = 32'd5; scan_end = 1;
    repeat (3) @(posedge clk);
    #1;
    bin_valid = 0; scan_end = 0;
    repeat (3) @(posedge clk);
    #1;
    check(m_n == 0, "R2", "buckets from idle bins", m_n, 0);
    check(done_n == 1, "R2", "done from idle end", done_n, 1);
  endtask

  task automatic t_reset();
    #1;
    check(ready == 0, "R2", "reset ready", ready, 0);
    check(bkt_valid == 0, "R6", "reset bkt_valid", bkt_valid, 0);
    check(done == 0, "R6", "reset done", done, 0);
    check(fwd_valid == 0, "R7", "reset fwd_valid", fwd_valid, 0);
  endtask

  // R3 R4: target 25, overshoot with 24+40, gap cycles, flushed tail
  task automatic t_threshold();
    set_bin(0, 10, 0, 0); set_bin(1, 10, 0, 1); set_bin(2, 10, 0, 0);
    set_bin(3, 25, 0, 0); set_bin(4, 24, 0, 1); set_bin(5, 40, 0, 0);
    set_bin(6, 5, 0, 0);  set_bin(7, 5, 0, 0);
    run_scan("R3", 0, 100, 4, 8, 0);
  endtask

  // R6: end arrives with the closing bin, so no flush follows
  task automatic t_end_on_close();
    set_bin(0, 20, 0, 0); set_bin(1, 7, 0, 0); set_bin(2, 13, 0, 0);
    run_scan("R6", 0, 60, 3, 3, 1);
  endtask

  // R6: end arrives with a non-closing bin, flushed together
  task automatic t_end_partial();
    set_bin(0, 9, 0, 0); set_bin(1, 2, 0, 0);
    run_scan("R6", 0, 40, 2, 2, 1);
  endtask

  // R5: flags decide, threshold of 500 ignored
  task automatic t_flag_mode();
    set_bin(0, 600, 0, 0); set_bin(1, 3, 1, 0); set_bin(2, 4, 0, 1);
    set_bin(3, 5, 1, 0);   set_bin(4, 9, 0, 0);
    run_scan("R5", 1, 1000, 2, 5, 0);
  endtask

  // R1 R9: zero buckets means one, target 20
  task automatic t_zero_buckets();
    set_bin(0, 5, 0, 0); set_bin(1, 5, 0, 0); set_bin(2, 5, 0, 0);
    set_bin(3, 5, 0, 0); set_bin(4, 1, 0, 0);
    run_scan("R9", 0, 20, 0, 5, 0);
  endtask

  // R3: target 0 closes on every bin, even a zero count
  task automatic t_zero_limit();
    set_bin(0, 0, 0, 0); set_bin(1, 2, 0, 0);
    run_scan("R3", 0, 3, 8, 2, 0);
  endtask

  // R4: single huge bin overshoots, then exact close leaves nothing to flush
  task automatic t_overshoot_exact();
    set_bin(0, 1000, 0, 0); set_bin(1, 10, 0, 0);
    run_scan("R4", 0, 10, 1, 2, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    #1 rst_n = 1;
    mon_on = 1;
    t_threshold();
    t_end_on_close();
    t_end_partial();
    t_flag_mode();
    t_zero_buckets();
    t_zero_limit();
    t_overshoot_exact();
    repeat (4) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule